// File: doc/BRIEF.md
# Multi-Locality Interrupt Enable and Status Unit

This unit keeps an interrupt-enable word and an interrupt-status word for each of several localities. All localities share one interrupt line. Neighbouring blocks report events as single-cycle pulses. Each pulse carries a locality number and a 4-bit source vector covering data-ready, status-valid, locality-change and ready-for-command. An event is recorded in a locality's status word, and raises the shared line, only when that locality has its master enable set and the matching source enable set.

Software reaches the unit through a simple register port. One port programs the enable word and clears status bits by writing ones to them. A second, combinational port reads the enable word, the status word, a fixed vector word and a fixed capability word. Only the locality that currently owns the interface may change its enable or status words. The owner is given by a valid flag and a locality number from the arbitration logic. The vector word returns the interrupt number chosen by a parameter. The capability word lists the supported sources and level-low signalling.

Top module: `tis_irq_ctrl`

## Requirements
- R1: After reset every locality's enable word reads 0x00000008, every status word reads 0, and `irq_o` is low.
- R2: An event for a locality with source vector bit 0, 1, 2 or 3 maps to status bit 0, 1, 2 or 7. The status bit is set, and `irq_o` goes high on the next clock, only when that locality's enable bit 31 and the same status-position enable bit are both 1. Otherwise the event leaves the status word and the line unchanged.
- R3: A write to the enable word (write select 0) stores only bits 31, 4, 3, 7, 2, 1 and 0 of the data; every other bit reads back 0.
- R4: A write to the status word (write select 1) clears each of bits 0, 1, 2 and 7 for which the data bit is 1. Other data bits have no effect.
- R5: Enable and status writes take effect only when `own_vld_i` is 1 and `own_loc_i` equals `wr_loc_i`; other writes leave all words unchanged.
- R6: `irq_o` falls on the clock after a status write that clears at least one set bit and leaves that locality's status word at zero. It stays high after a partial clear. An event raising the line in the same cycle keeps it high.
- R7: Read select 3 returns the capability word 0x00000097 for any locality, and writes with write select 3 have no effect.
- R8: Read select 2 returns the 4-bit parameter IRQ_NUM (range 0 to 15) zero-extended, and writes with write select 2 have no effect.
- R9: Events tagged with a locality number of NUM_LOC or above change nothing.
- R10: Read select 0 and 1 return the enable and status word of `rd_loc_i`; for a locality number of NUM_LOC or above they return 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_vld_i | input | 1 | A locality currently owns the interface |
| own_loc_i | input | LOC_W | Number of the owning locality |
| evt_vld_i | input | 1 | Event pulse |
| evt_loc_i | input | LOC_W | Locality the event belongs to |
| evt_src_i | input | 4 | Event sources: data-ready, status-valid, locality-change, ready-for-command |
| wr_en_i | input | 1 | Register write strobe |
| wr_loc_i | input | LOC_W | Locality issuing the write |
| wr_sel_i | input | 2 | Write target: 0 enable, 1 status, 2 vector, 3 capability |
| wr_data_i | input | 32 | Write data |
| rd_loc_i | input | LOC_W | Locality to read |
| rd_sel_i | input | 2 | Read target, same encoding as the write select |
| rd_data_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Shared interrupt line, high when asserted |

## Verification
Properties check several rules on every cycle. A status bit can only appear when the master enable and its source enable were already set. Unsupported status bits never appear. An enable word stays unchanged without a qualified write. A write from a locality that does not own the interface never reaches a locality's registers. The line only rises after an accepted event and only falls after a clearing write. The exact values are shown only by the bench's scenarios: the masked enable read-back, the partial versus full clear of the status word, event and clear landing in the same cycle, the fixed vector and capability words, and the reads of missing localities.

// File: rtl/tis_irq_pkg.sv
package tis_irq_pkg;

    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_VECTOR = 2'd2,
        SEL_CAPAB  = 2'd3
    } reg_sel_e;

    localparam int                 MASTER_BIT = 31;
    localparam logic [REG_W-1:0] SRC_MASK   = 32'h0000_0087;
    localparam logic [REG_W-1:0] POL_MASK   = 32'h0000_0018;
    localparam logic [REG_W-1:0] ENA_WMASK  = 32'h8000_0000 | POL_MASK | SRC_MASK;
    localparam logic [REG_W-1:0] ENA_RESET  = 32'h0000_0008;
    localparam logic [REG_W-1:0] CAP_VALUE  = 32'h0000_0010 | SRC_MASK;

    typedef struct packed {
        logic [REG_W-1:0] inte;
        logic [REG_W-1:0] ints;
    } loc_state_t;

    function automatic logic [REG_W-1:0] src_to_bits(input logic [3:0] src);
        logic [REG_W-1:0] b;
        b      = '0;
        b[2:0] = src[2:0];
        b[7]   = src[3];
        return b;
    endfunction

endpackage

// File: rtl/tis_irq_loc.sv
module tis_irq_loc
    import tis_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  reg_sel_e         wsel_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             evt_i,
    input  logic [REG_W-1:0] evt_bits_i,
    output logic [REG_W-1:0] inte_o,
    output logic [REG_W-1:0] ints_o,
    output logic             raise_o,
    output logic             drop_o
);

    loc_state_t st_d, st_q;
    logic [REG_W-1:0] hit_bits;
    logic [REG_W-1:0] clr_bits;

    always_comb begin
        st_d     = st_q;
        drop_o   = 1'b0;
        clr_bits = '0;
        hit_bits = '0;

        if (evt_i && st_q.inte[MASTER_BIT]) begin
            hit_bits = evt_bits_i & st_q.inte & SRC_MASK;
        end

        if (we_i && wsel_i == SEL_ENABLE) begin
            st_d.inte = wdata_i & ENA_WMASK;
        end

        if (we_i && wsel_i == SEL_STATUS) begin
            clr_bits  = wdata_i & SRC_MASK;
            st_d.ints = st_q.ints & ~clr_bits;
            drop_o    = (clr_bits != '0) && ((st_q.ints & SRC_MASK) != '0)
                        && (st_d.ints == '0);
        end

        st_d.ints = st_d.ints | hit_bits;
        raise_o   = (hit_bits != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.inte <= ENA_RESET;
            st_q.ints <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inte_o = st_q.inte;
    assign ints_o = st_q.ints;

    // R2: a newly set status bit needs the master enable and an event
    a_r2_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.ints & ~$past(st_q.ints)) != '0) |-> $past(st_q.inte[MASTER_BIT] && evt_i));

    // R2: a newly set status bit needs its own source enable
    a_r2_source_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ints & ~$past(st_q.ints) & ~$past(st_q.inte)) == '0);

    // R4: only supported source positions are ever held
    a_r4_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ints & ~SRC_MASK) == '0);

    // R5: without a qualified write the enable word holds
    a_r5_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(st_q.inte));

endmodule

// File: rtl/tis_irq_line.sv
module tis_irq_line #(
    parameter int NUM_LOC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LOC-1:0] raise_i,
    input  logic [NUM_LOC-1:0] drop_i,
    output logic               irq_o
);

    logic irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (|drop_i)  irq_d = 1'b0;
        if (|raise_i) irq_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;

    // R2: the line only rises after an accepted event
    a_r2_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(|raise_i));

    // R6: the line only falls after a clearing write with no competing event
    a_r6_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_q) |-> $past((|drop_i) && !(|raise_i)));

endmodule

// File: rtl/tis_irq_rdmux.sv
module tis_irq_rdmux
    import tis_irq_pkg::*;
#(
    parameter int         NUM_LOC = 5,
    parameter int         LOC_W   = 3,
    parameter logic [3:0] IRQ_NUM = 4'd11
) (
    input  logic [REG_W-1:0] inte_i [NUM_LOC],
    input  logic [REG_W-1:0] ints_i [NUM_LOC],
    input  logic [LOC_W-1:0] rd_loc_i,
    input  reg_sel_e         rd_sel_i,
    output logic [REG_W-1:0] rd_data_o
);

    logic [REG_W-1:0] inte_sel, ints_sel;

    always_comb begin
        inte_sel = '1;
        ints_sel = '1;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (rd_loc_i == LOC_W'(i)) begin
                inte_sel = inte_i[i];
                ints_sel = ints_i[i];
            end
        end
        case (rd_sel_i)
            SEL_ENABLE: rd_data_o = inte_sel;
            SEL_STATUS: rd_data_o = ints_sel;
            SEL_VECTOR: rd_data_o = {{(REG_W-4){1'b0}}, IRQ_NUM};
            default:    rd_data_o = CAP_VALUE;
        endcase
    end

endmodule

// File: rtl/tis_irq_ctrl.sv
module tis_irq_ctrl
    import tis_irq_pkg::*;
#(
    parameter int         NUM_LOC = 5,
    parameter int         LOC_W   = $clog2(NUM_LOC),
    parameter logic [3:0] IRQ_NUM = 4'd11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             own_vld_i,
    input  logic [LOC_W-1:0] own_loc_i,
    input  logic             evt_vld_i,
    input  logic [LOC_W-1:0] evt_loc_i,
    input  logic [3:0]       evt_src_i,
    input  logic             wr_en_i,
    input  logic [LOC_W-1:0] wr_loc_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [31:0]      wr_data_i,
    input  logic [LOC_W-1:0] rd_loc_i,
    input  logic [1:0]       rd_sel_i,
    output logic [31:0]      rd_data_o,
    output logic             irq_o
);

    logic [REG_W-1:0]   inte_w [NUM_LOC];
    logic [REG_W-1:0]   ints_w [NUM_LOC];
    logic [NUM_LOC-1:0] we_vec, evt_vec, raise_vec, drop_vec;
    logic [REG_W-1:0]   evt_bits;
    logic               wr_owner;

    assign evt_bits = src_to_bits(evt_src_i);
    assign wr_owner = wr_en_i && own_vld_i && (own_loc_i == wr_loc_i);

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
        assign we_vec[g]  = wr_owner && (wr_loc_i == LOC_W'(g));
        assign evt_vec[g] = evt_vld_i && (evt_loc_i == LOC_W'(g));

        tis_irq_loc u_loc (
            .clk        (clk),
            .rst_n      (rst_n),
            .we_i       (we_vec[g]),
            .wsel_i     (reg_sel_e'(wr_sel_i)),
            .wdata_i    (wr_data_i),
            .evt_i      (evt_vec[g]),
            .evt_bits_i (evt_bits),
            .inte_o     (inte_w[g]),
            .ints_o     (ints_w[g]),
            .raise_o    (raise_vec[g]),
            .drop_o     (drop_vec[g])
        );
    end

    tis_irq_line #(.NUM_LOC(NUM_LOC)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .raise_i (raise_vec),
        .drop_i  (drop_vec),
        .irq_o   (irq_o)
    );

    tis_irq_rdmux #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .IRQ_NUM(IRQ_NUM)) u_rd (
        .inte_i    (inte_w),
        .ints_i    (ints_w),
        .rd_loc_i  (rd_loc_i),
        .rd_sel_i  (reg_sel_e'(rd_sel_i)),
        .rd_data_o (rd_data_o)
    );

    // R5: a write from a locality that does not own the interface reaches no register
    a_r5_owner_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !(own_vld_i && own_loc_i == wr_loc_i)) |-> (we_vec == '0));

    // R9: events for missing localities reach no register
    a_r9_bad_loc: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld_i && (32'(evt_loc_i) >= NUM_LOC)) |-> (evt_vec == '0));

    // R6: the line never rises without an event pulse at the port
    a_r6_rise_port: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(evt_vld_i));

endmodule

// File: tb/tis_irq_ctrl_tb.sv
module tis_irq_ctrl_tb_top;

    localparam int LOC_W = 3;

    localparam logic [2:0] OP_RD  = 3'd0;
    localparam logic [2:0] OP_WR  = 3'd1;
    localparam logic [2:0] OP_EVT = 3'd2;
    localparam logic [2:0] OP_ACT = 3'd3;
    localparam logic [2:0] OP_IRQ = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [2:0]  loc;
        logic [1:0]  sel;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 41;
    localparam vec_t VECS [NV] = '{
        '{OP_RD,  3'd0, 2'd0, 32'h0,        32'h0000_0008, 4'd1},  // R1 enable reset
        '{OP_RD,  3'd4, 2'd1, 32'h0,        32'h0000_0000, 4'd1},  // R1 status reset
        '{OP_IRQ, 3'd0, 2'd0, 32'h0,        32'h0,         4'd1},  // R1 line low
        '{OP_RD,  3'd0, 2'd3, 32'h0,        32'h0000_0097, 4'd7},  // R7 capability
        '{OP_RD,  3'd0, 2'd2, 32'h0,        32'h0000_000B, 4'd8},  // R8 vector
        '{OP_WR,  3'd1, 2'd0, 32'hFFFF_FFFF, 32'h0,        4'd5},  // R5 no owner
        '{OP_RD,  3'd1, 2'd0, 32'h0,        32'h0000_0008, 4'd5},
        '{OP_ACT, 3'd1, 2'd0, 32'h1,        32'h0,         4'd5},
        '{OP_WR,  3'd1, 2'd0, 32'hFFFF_FFFF, 32'h0,        4'd3},  // R3 mask
        '{OP_RD,  3'd1, 2'd0, 32'h0,        32'h8000_009F, 4'd3},
        '{OP_EVT, 3'd1, 2'd0, 32'h1,        32'h0,         4'd2},  // R2 data-ready
        '{OP_RD,  3'd1, 2'd1, 32'h0,        32'h0000_0001, 4'd2},
        '{OP_IRQ, 3'd0, 2'd0, 32'h0,        32'h1,         4'd2},
        '{OP_EVT, 3'd1, 2'd0, 32'h8,        32'h0,         4'd2},  // R2 ready-for-command -> bit 7
        '{OP_RD,  3'd1, 2'd1, 32'h0,        32'h0000_0081, 4'd2},
        '{OP_WR,  3'd1, 2'd1, 32'h1,        32'h0,         4'd4},  // R4 partial clear
        '{OP_RD,  3'd1, 2'd1, 32'h0,        32'h0000_0080, 4'd4},
        '{OP_IRQ, 3'd0, 2'd0, 32'h0,        32'h1,         4'd6},  // R6 stays high
        '{OP_WR,  3'd1, 2'd1, 32'h80,       32'h0,         4'd6},
        '{OP_IRQ, 3'd0, 2'd0, 32'h0,        32'h0,         4'd6},  // R6 falls
        '{OP_WR,  3'd1, 2'd0, 32'h87,       32'h0,         4'd2},  // master off
        '{OP_EVT, 3'd1, 2'd0, 32'hF,        32'h0,         4'd2},
        '{OP_RD,  3'd1, 2'd1, 32'h0,        32'h0000_0000, 4'd2},  // R2 master gate
        '{OP_IRQ, 3'd0, 2'd0, 32'h0,        32'h0,         4'd2},
        '{OP_WR,  3'd1, 2'd0, 32'h8000_0002, 32'h0,        4'd2},
        '{OP_EVT, 3'd1, 2'd0, 32'h5,        32'h0,         4'd2},
        '{OP_RD,  3'd1, 2'd1, 32'h0,        32'h0000_0000, 4'd2},  // R2 source gate
        '{OP_EVT, 3'd1, 2'd0, 32'h2,        32'h0,         4'd2},
        '{OP_RD,  3'd1, 2'd1, 32'h0,        32'h0000_0002, 4'd2},
        '{OP_IRQ, 3'd0, 2'd0, 32'h0,        32'h1,         4'd2},
        '{OP_WR,  3'd1, 2'd2, 32'hFF,       32'h0,         4'd8},  // R8 vector write ignored
        '{OP_RD,  3'd1, 2'd2, 32'h0,        32'h0000_000B, 4'd8},
        '{OP_WR,  3'd1, 2'd3, 32'h0,        32'h0,         4'd7},  // R7 capability write ignored
        '{OP_RD,  3'd1, 2'd3, 32'h0,        32'h0000_0097, 4'd7},
        '{OP_WR,  3'd1, 2'd1, 32'hFFFF_FFFF, 32'h0,        4'd4},
        '{OP_IRQ, 3'd0, 2'd0, 32'h0,        32'h0,         4'd6},
        '{OP_EVT, 3'd5, 2'd0, 32'hF,        32'h0,         4'd9},  // R9 missing locality
        '{OP_IRQ, 3'd0, 2'd0, 32'h0,        32'h0,         4'd9},
        '{OP_WR,  3'd2, 2'd0, 32'h8000_0001, 32'h0,        4'd5},  // R5 non-owner
        '{OP_RD,  3'd2, 2'd0, 32'h0,        32'h0000_0008, 4'd5},
        '{OP_RD,  3'd6, 2'd0, 32'h0,        32'hFFFF_FFFF, 4'd10}  // R10 missing locality read
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             own_vld = 1'b0;
    logic [LOC_W-1:0] own_loc = '0;
    logic             evt_vld = 1'b0;
    logic [LOC_W-1:0] evt_loc = '0;
    logic [3:0]       evt_src = '0;
    logic             wr_en = 1'b0;
    logic [LOC_W-1:0] wr_loc = '0;
    logic [1:0]       wr_sel = '0;
    logic [31:0]      wr_data = '0;
    logic [LOC_W-1:0] rd_loc = '0;
    logic [1:0]       rd_sel = '0;
    logic [31:0]      rd_data;
    logic             irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tis_irq_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_vld_i (own_vld),
        .own_loc_i (own_loc),
        .evt_vld_i (evt_vld),
        .evt_loc_i (evt_loc),
        .evt_src_i (evt_src),
        .wr_en_i   (wr_en),
        .wr_loc_i  (wr_loc),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .rd_loc_i  (rd_loc),
        .rd_sel_i  (rd_sel),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_read(input string tag, input logic [2:0] loc, input logic [1:0] sel,
                           input logic [31:0] exp);
        @(negedge clk);
        rd_loc = loc;
        rd_sel = sel;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic do_irq(input string tag, input logic exp);
        @(negedge clk);
        #1;
        check(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic do_write(input logic [2:0] loc, input logic [1:0] sel, input logic [31:0] d,
                            input bit with_evt, input logic [2:0] eloc, input logic [3:0] src);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_loc  = loc;
        wr_sel  = sel;
        wr_data = d;
        evt_vld = with_evt;
        evt_loc = eloc;
        evt_src = src;
        @(negedge clk);
        wr_en   = 1'b0;
        evt_vld = 1'b0;
    endtask

    task automatic do_event(input logic [2:0] loc, input logic [3:0] src);
        @(negedge clk);
        evt_vld = 1'b1;
        evt_loc = loc;
        evt_src = src;
        @(negedge clk);
        evt_vld = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got 0x00000000 expected 0x00000001");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vector %0d", VECS[i].req, i);
            case (VECS[i].op)
                OP_RD:  do_read(tag, VECS[i].loc, VECS[i].sel, VECS[i].exp);
                OP_IRQ: do_irq(tag, VECS[i].exp[0]);
                OP_WR:  do_write(VECS[i].loc, VECS[i].sel, VECS[i].data, 1'b0, 3'd0, 4'd0);
                OP_EVT: do_event(VECS[i].loc, VECS[i].data[3:0]);
                OP_ACT: begin
                    @(negedge clk);
                    own_vld = VECS[i].data[0];
                    own_loc = VECS[i].loc;
                end
                default: ;
            endcase
        end

        // R6: clear and event in the same cycle keep the line high
        do_write(3'd1, 2'd0, 32'h8000_0001, 1'b0, 3'd0, 4'd0);
        do_event(3'd1, 4'h1);
        do_irq("R6 line up before race", 1'b1);
        do_write(3'd1, 2'd1, 32'h1, 1'b1, 3'd1, 4'h1);
        do_read("R6 status after race", 3'd1, 2'd1, 32'h1);
        do_irq("R6 line after race", 1'b1);

        // R4: unsupported positions in the clear data do nothing
        do_write(3'd1, 2'd1, 32'h0000_0078, 1'b0, 3'd0, 4'd0);
        do_read("R4 unsupported clear bits", 3'd1, 2'd1, 32'h1);
        do_irq("R4 line after unsupported clear", 1'b1);

        // R1: reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_read("R1 enable after reset", 3'd1, 2'd0, 32'h8);
        do_read("R1 status after reset", 3'd1, 2'd1, 32'h0);
        do_irq("R1 line after reset", 1'b0);

        finish_run();
    end

endmodule